// File: doc/BRIEF.md
# Iterative Multiply Coprocessor

This unit sits on a processor's coprocessor port and executes the four 32-bit integer multiply instructions: low-word multiply, and the three high-word forms (signed by signed, signed by unsigned, unsigned by unsigned). The processor presents a valid strobe together with the instruction word and the two source operand values. The unit decodes the word. If the word is one of its own, it raises its busy (wait) flag on the next clock edge so that the processor's 16-cycle no-acknowledge fault never fires. It then forms the product with a shift-and-add loop that retires one multiplier bit per clock.

The loop runs for 32 steps when only the low word is wanted and for 64 steps for the high-word forms, because a sign-extended multiplier needs all 64 bits. When the loop ends, the unit drives the 32-bit result together with a write flag and a one-cycle done pulse. The processor writes the result into the destination register named in the instruction. Words that do not match are never acknowledged, which leaves them to other coprocessors or to the processor's fault path.

Top module: `mulcp_top`

## Requirements
- R1: A word is accepted only when bits [6:0] are 0110011, bits [31:25] are 0000001 and bit 14 is 0 (bits [14:12] one of 000, 001, 010, 011). For any other word, busy, done and write all stay low however long valid is held.
- R2: Busy is high from the first clock edge that samples valid with a matching word. It stays high without a gap until the edge that raises done, and it is low while done is high.
- R3: With bits [14:12] = 000, the result is the low 32 bits of the product of the two operands.
- R4: With bits [14:12] = 001, the result is the high 32 bits of the 64-bit product of both operands taken as signed.
- R5: With bits [14:12] = 010, the result is the high 32 bits of the product of the first operand taken as signed and the second taken as unsigned.
- R6: With bits [14:12] = 011, the result is the high 32 bits of the product of both operands taken as unsigned.
- R7: Done is first seen high 33 clock edges after the accepting edge for the low-word form, and 65 edges after it for the high-word forms.
- R8: Done and write are high together for exactly one cycle, and the result is valid in that cycle.
- R9: After done, no new word is accepted until valid has been sampled low at least once.
- R10: While reset is high, and on the first cycle after it, busy, done and write are low. A reset in the middle of a multiply abandons it.
- R11: The operands and the word are sampled only at the accepting edge. Changes to them during the loop do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor offers an instruction |
| req_insn | input | 32 | Instruction word |
| req_op_a | input | 32 | First source operand value |
| req_op_b | input | 32 | Second source operand value |
| rsp_write | output | 1 | Result is to be written to the destination register |
| rsp_result | output | 32 | Result value |
| rsp_busy | output | 1 | Instruction claimed and in progress |
| rsp_done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a processor that misbehaves around the handshake. One case is a processor that keeps valid high after done. The other is one that changes the operands while the loop is still running. The stimulus holds valid high for several cycles after done and checks that nothing is claimed again. It also scrambles the operands two cycles into selected multiplies and checks that the result still matches the values present at acceptance. A reset is also asserted in the middle of a high-word multiply to confirm that the operation is abandoned and the next one runs cleanly.

// File: rtl/mulcp_pkg.sv
package mulcp_pkg;
  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] F7_MUL  = 7'b0000001;

  typedef enum logic [1:0] {
    MK_LO  = 2'd0,
    MK_HSS = 2'd1,
    MK_HSU = 2'd2,
    MK_HUU = 2'd3
  } mul_kind_e;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_RUN  = 2'd1,
    CS_FIN  = 2'd2,
    CS_HOLD = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/mulcp_decode.sv
module mulcp_decode
  import mulcp_pkg::*;
(
  input  logic [31:0] insn,
  output logic        hit,
  output mul_kind_e   kind
);
  logic unused_fields;
  assign unused_fields = ^{insn[24:15], insn[11:7], insn[13:12] == 2'b00};

  always_comb begin
    hit  = (insn[6:0] == OPC_REG) && (insn[31:25] == F7_MUL) && !insn[14];
    kind = mul_kind_e'(insn[13:12]);
  end
endmodule

// File: rtl/mulcp_ctrl.sv
module mulcp_ctrl
  import mulcp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic hit,
  input  logic want_hi,
  output logic load,
  output logic step,
  output logic capture,
  output logic busy_q,
  output logic done_q,
  output logic wr_q
);
  localparam int PW = 2 * XLEN;
  localparam int CW = $clog2(PW + 1);
  localparam logic [CW-1:0] LAST_LO = CW'(XLEN - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(PW - 1);

  ctl_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic hi_q;

  always_comb begin
    load    = (state_q == CS_IDLE) && valid && hit;
    step    = (state_q == CS_RUN);
    capture = (state_q == CS_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CS_IDLE;
      cnt_q   <= '0;
      hi_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      case (state_q)
        CS_IDLE: if (load) begin
          state_q <= CS_RUN;
          cnt_q   <= '0;
          hi_q    <= want_hi;
          busy_q  <= 1'b1;
        end
        CS_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == (hi_q ? LAST_HI : LAST_LO)) state_q <= CS_FIN;
        end
        CS_FIN: begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          wr_q    <= 1'b1;
          state_q <= CS_HOLD;
        end
        default: begin
          done_q <= 1'b0;
          wr_q   <= 1'b0;
          if (!valid) state_q <= CS_IDLE;
        end
      endcase
    end
  end

  AST_NO_WAIT_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && done_q)); // R2
  AST_WAIT_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q); // R2
  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(PW)); // R7
  AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !busy_q); // R9
endmodule

// File: rtl/mulcp_datapath.sv
module mulcp_datapath
  import mulcp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            step,
  input  logic            capture,
  input  mul_kind_e       kind,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic [XLEN-1:0] result
);
  localparam int PW = 2 * XLEN;

  logic [PW-1:0] mcand_q, mplier_q, acc_q;
  logic          hi_q;
  logic          a_sgn, b_sgn;
  logic [PW-1:0] a_ext, b_ext;

  always_comb begin
    a_sgn = (kind == MK_HSS) || (kind == MK_HSU);
    b_sgn = (kind == MK_HSS);
    a_ext = {{XLEN{a_sgn & op_a[XLEN-1]}}, op_a};
    b_ext = {{XLEN{b_sgn & op_b[XLEN-1]}}, op_b};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      hi_q     <= 1'b0;
      result   <= '0;
    end else begin
      if (load) begin
        mcand_q  <= a_ext;
        mplier_q <= b_ext;
        acc_q    <= '0;
        hi_q     <= (kind != MK_LO);
      end else if (step) begin
        if (mplier_q[0]) acc_q <= acc_q + mcand_q;
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
      end
      if (capture) result <= hi_q ? acc_q[PW-1:XLEN] : acc_q[XLEN-1:0];
    end
  end

  AST_CAPTURE_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    capture |-> $past(step)); // R7
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !$past(capture) && !capture |=> $stable(result)); // R11
endmodule

// File: rtl/mulcp_top.sv
module mulcp_top
  import mulcp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [31:0]     req_insn,
  input  logic [XLEN-1:0] req_op_a,
  input  logic [XLEN-1:0] req_op_b,
  output logic            rsp_write,
  output logic [XLEN-1:0] rsp_result,
  output logic            rsp_busy,
  output logic            rsp_done
);
  logic      dec_hit;
  mul_kind_e dec_kind;
  logic      c_load, c_step, c_capture;

  mulcp_decode u_dec (
    .insn (req_insn),
    .hit  (dec_hit),
    .kind (dec_kind)
  );

  mulcp_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .valid   (req_valid),
    .hit     (dec_hit),
    .want_hi (dec_kind != MK_LO),
    .load    (c_load),
    .step    (c_step),
    .capture (c_capture),
    .busy_q  (rsp_busy),
    .done_q  (rsp_done),
    .wr_q    (rsp_write)
  );

  mulcp_datapath #(.XLEN(XLEN)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .load    (c_load),
    .step    (c_step),
    .capture (c_capture),
    .kind    (dec_kind),
    .op_a    (req_op_a),
    .op_b    (req_op_b),
    .result  (rsp_result)
  );

  AST_ACCEPT_ONLY_OWN: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_busy) |-> $past(req_valid && dec_hit)); // R1
  AST_WRITE_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    rsp_write |-> rsp_done); // R8
endmodule

// File: tb/mulcp_top_test.sv
module mulcp_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam logic [31:0] TA [NV] = '{32'h0000_0007, 32'h8000_0000, 32'hFFFF_FFFF,
    32'hFFFF_FFFF, 32'h1234_5678, 32'h8000_0000, 32'h7FFF_FFFF, 32'hDEAD_BEEF,
    32'h0000_0000, 32'hFFFF_FFFE};
  localparam logic [31:0] TB [NV] = '{32'h0000_0006, 32'h8000_0000, 32'hFFFF_FFFF,
    32'hFFFF_FFFF, 32'h9ABC_DEF0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hCAFE_F00D,
    32'h1234_5678, 32'h0000_0003};
  localparam logic [2:0] TF [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd0, 3'd1, 3'd2, 3'd3,
    3'd1, 3'd0};

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_insn = '0, req_op_a = '0, req_op_b = '0;
  logic rsp_write, rsp_busy, rsp_done;
  logic [31:0] rsp_result;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  mulcp_top uut (.clk(clk), .rst(rst), .req_valid(req_valid), .req_insn(req_insn),
    .req_op_a(req_op_a), .req_op_b(req_op_b), .rsp_write(rsp_write),
    .rsp_result(rsp_result), .rsp_busy(rsp_busy), .rsp_done(rsp_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
    logic signed [64:0] sa, sb;
    logic signed [129:0] p;
    sa = (f3 == 3'd1 || f3 == 3'd2) ? $signed({{33{a[31]}}, a}) : $signed({33'b0, a});
    sb = (f3 == 3'd1) ? $signed({{33{b[31]}}, b}) : $signed({33'b0, b});
    p = sa * sb;
    return (f3 == 3'd0) ? p[31:0] : p[63:32];
  endfunction

  function automatic string tag_of(input logic [2:0] f3);
    case (f3)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic do_op(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b, input bit scramble);
    logic [31:0] exp;
    int lat, k;
    bit got, gap;
    exp = model(f3, a, b);
    lat = (f3 == 3'd0) ? 34 : 66;
    @(negedge clk);
    req_valid = 1'b1;
    req_insn = {7'b0000001, 5'd7, 5'd3, f3, 5'd9, 7'b0110011};
    req_op_a = a;
    req_op_b = b;
    k = 0; got = 1'b0; gap = 1'b0;
    while (!got && k < 200) begin
      @(negedge clk);
      k++;
      if (scramble && k == 2) begin
        req_op_a = ~a;
        req_op_b = b ^ 32'h5A5A_A5A5;
        req_insn[13:12] = ~f3[1:0];
      end
      got = rsp_done;
      if (!got && !rsp_busy) gap = 1'b1;
    end
    chk(!gap, "R2 busy held until done", 64'(gap), 0);
    chk(k == lat, "R7 latency", 64'(k), 64'(lat));
    chk(!rsp_busy, "R2 busy low with done", 64'(rsp_busy), 0);
    chk(rsp_write, "R8 write with done", 64'(rsp_write), 1);
    chk(rsp_result == exp, scramble ? "R11 operands sampled at accept" : tag_of(f3),
        64'(rsp_result), 64'(exp));
    req_valid = 1'b0;
    @(negedge clk);
    chk(!rsp_done && !rsp_write, "R8 single-cycle pulse", {rsp_done, rsp_write}, 0);
  endtask

  task automatic no_match(input logic [31:0] w);
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_insn = w;
    req_op_a = 32'h1111_2222;
    req_op_b = 32'h3333_4444;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rsp_busy || rsp_done || rsp_write) seen = 1'b1;
    end
    chk(!seen, "R1 foreign word ignored", 64'(seen), 0);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rsp_busy && !rsp_done && !rsp_write, "R10 in reset", {rsp_busy, rsp_done, rsp_write}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rsp_busy && !rsp_done && !rsp_write, "R10 after reset", {rsp_busy, rsp_done, rsp_write}, 0);

    for (int i = 0; i < NV; i++) do_op(TF[i], TA[i], TB[i], 1'b0);

    no_match({7'b0000001, 5'd7, 5'd3, 3'b100, 5'd9, 7'b0110011});
    no_match({7'b0000000, 5'd7, 5'd3, 3'b000, 5'd9, 7'b0110011});
    no_match({7'b0000001, 5'd7, 5'd3, 3'b000, 5'd9, 7'b0110111});
    no_match({7'b0000011, 5'd7, 5'd3, 3'b011, 5'd9, 7'b0110011});

    do_op(3'd1, 32'hF000_0001, 32'h8765_4321, 1'b1);
    do_op(3'd0, 32'hABCD_0123, 32'h0F0F_F0F0, 1'b1);

    begin : r9_hold
      bit seen;
      int k;
      seen = 1'b0;
      @(negedge clk);
      req_valid = 1'b1;
      req_insn = {7'b0000001, 5'd7, 5'd3, 3'b000, 5'd9, 7'b0110011};
      req_op_a = 32'd5;
      req_op_b = 32'd9;
      k = 0;
      while (!rsp_done && k < 200) begin @(negedge clk); k++; end
      chk(rsp_result == 32'd45, "R3 product before hold", 64'(rsp_result), 45);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (rsp_busy || rsp_done) seen = 1'b1;
      end
      chk(!seen, "R9 no re-accept while valid held", 64'(seen), 0);
      req_valid = 1'b0;
    end

    do_op(3'd3, 32'h0000_0010, 32'h1000_0000, 1'b0);

    @(negedge clk);
    req_valid = 1'b1;
    req_insn = {7'b0000001, 5'd7, 5'd3, 3'b001, 5'd9, 7'b0110011};
    req_op_a = 32'h7;
    req_op_b = 32'h7;
    repeat (10) @(negedge clk);
    chk(rsp_busy, "R2 busy during loop", 64'(rsp_busy), 1);
    req_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (80) @(negedge clk);
    chk(!rsp_busy && !rsp_done, "R10 mid-op reset abandons", {rsp_busy, rsp_done}, 0);
    do_op(3'd2, 32'hFFFF_FFF0, 32'h0000_0100, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule